// File: doc/BRIEF.md
# Dual-Mode Host Bus Slave

This block is the host-facing slave port of a larger device. An external CPU uses it to read and write 16-bit words, either in a small internal register file or, through a request/grant port, in a memory that sits behind the block. A static strap picks the handshake style. With the strap at 1 the two control pins are separate active-low write and read strobes, and the handshake pin is a driven ready line. With the strap at 0 the same pins carry a read/write level and an active-low data strobe, and the handshake pin becomes an active-low acknowledge that drives low, drives high for one clock, then floats.

Chip select and both control pins pass through two-flop synchronisers before the access state machine sees them. A separate select input, sampled at the start of each access, steers the access to the register file (low) or to the memory port (high). The handshake completes only once read data has been captured or write data has been taken by the target. Pin drivers are outside the block, so every three-state or open-drain pin is modelled as a value plus a drive enable. An active-low open-drain interrupt is modelled as a single pull-low enable that follows a vector of request lines.

Top module: `hostbus_slave`

## Requirements
- R1: With `mode_intel`=1 and `cs_n`=0, `wr_rw`=0 starts a write and `rd_ds_n`=0 with `wr_rw`=1 starts a read. If both are low, the access is a write.
- R2: With `mode_intel`=0 and `cs_n`=0, `rd_ds_n`=0 starts an access that is a read when `wr_rw`=1 and a write when `wr_rw`=0.
- R3: While `cs_n`=1, activity on the strobes starts no access: no memory request is raised and no register changes.
- R4: With `ext_sel`=1, the access goes to the memory port with `mem_addr` equal to `addr`. `mem_addr` and `mem_wdata` hold steady until the grant. With `ext_sel`=0, the access goes to register `addr[2:0]`, since the default has 8 registers and upper address bits alias.
- R5: In strap-1 mode, `hs_oe` equals `~cs_n` at all times. `hs_out` reads 1 only once the access has completed.
- R6: In strap-0 mode, `hs_oe` is 0 when idle. On completion `hs_out`=0 is driven until the strobe is seen released. Then `hs_out`=1 is driven for exactly one clock, after which `hs_oe` returns to 0.
- R7: `data_oe` is 1 only during a read access with `cs_n`=0 and the read/data strobe low. It drops as soon as the strobe rises, and `data_out` carries the read word at completion.
- R8: A single strobe assertion commits exactly one write, however long it is held.
- R9: A memory access raises `mem_req` and keeps it up until a clock with `mem_gnt`=1. The handshake does not signal completion while `mem_req` is high.
- R10: `int_drive` (the pull-low enable of the interrupt pin) is 1 on the clock after any bit of `irq_req` is 1, and 0 on the clock after all are 0.
- R11: After reset, all registers read 0 and `data_oe`, `mem_req` and `int_drive` are 0. In strap-0 mode `hs_oe` is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_intel | input | 1 | Strap: 1 separate strobes + ready, 0 R/W level + data strobe + acknowledge |
| cs_n | input | 1 | Active-low chip select |
| wr_rw | input | 1 | Write strobe (active low) or read/write level (1 read) |
| rd_ds_n | input | 1 | Read strobe or data strobe, active low |
| addr | input | 15 | Word address |
| ext_sel | input | 1 | 1 routes the access to the memory port |
| data_in | input | 16 | Write data from host |
| data_out | output | 16 | Read data to host |
| data_oe | output | 1 | Data bus drive enable |
| hs_out | output | 1 | Handshake pin value |
| hs_oe | output | 1 | Handshake pin drive enable |
| int_drive | output | 1 | Interrupt pin pull-low enable |
| irq_req | input | 4 | Interrupt request lines |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with grant |
| mem_gnt | input | 1 | Memory grant, one clock |

## Verification
The access path is driven in both strap modes with reads and writes to registers and to memory. Memory grant latencies of one and six clocks separate a handshake that waits for the grant from one that fires early. Register addresses above the file size show whether index aliasing is correct. Strobes held long after completion separate once-per-strobe commits from repeated ones. Strobe pulses with chip select high show whether select gating is in place.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;
    localparam int HB_DW = 16;
    localparam int HB_AW = 15;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_ACK  = 2'd2,
        ST_REL  = 2'd3
    } hb_state_e;

    typedef struct packed {
        logic              wr;
        logic [HB_AW-1:0]  addr;
        logic [HB_DW-1:0]  wdata;
    } hb_access_t;

    // Access request from synchronised pins.
    function automatic logic strobe_active(input logic intel, input logic cs_n,
                                           input logic wr_rw, input logic rd_ds_n);
        if (cs_n) return 1'b0;
        return intel ? (!wr_rw || !rd_ds_n) : !rd_ds_n;
    endfunction

    // Raw-pin read-strobe qualifier used for the data bus enable.
    function automatic logic read_strobe(input logic intel, input logic wr_rw,
                                         input logic rd_ds_n);
        return intel ? !rd_ds_n : (!rd_ds_n && wr_rw);
    endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W = 1,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[i] <= RST_VAL;
                stage2[i] <= RST_VAL;
            end else begin
                stage1[i] <= din[i];
                stage2[i] <= stage1[i];
            end
        end
    end

    assign dout = stage2;
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile #(
    parameter int NREGS = 8,
    parameter int DW    = 16,
    localparam int IW   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] regs [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (we && (idx == IW'(i))) begin
                regs[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NREGS; k++) begin
            if (idx == IW'(k)) rdata = regs[k];
        end
    end
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
    import hostbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_intel,
    input  logic              cs_s,
    input  logic              wr_s,
    input  logic              rd_s,
    input  logic              ext_sel,
    input  logic [HB_AW-1:0]  addr,
    input  logic [HB_DW-1:0]  data_in,
    input  logic [HB_DW-1:0]  reg_rdata,
    input  logic              mem_gnt,
    input  logic [HB_DW-1:0]  mem_rdata,
    output logic              reg_we,
    output hb_access_t        acc,
    output logic              mem_req,
    output logic [HB_DW-1:0]  rdata,
    output logic              rd_cycle,
    output logic              ack_phase,
    output logic              rel_phase
);
    hb_state_e state;
    logic      active;

    assign active = strobe_active(mode_intel, cs_s, wr_s, rd_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            acc      <= '0;
            rdata    <= '0;
            rd_cycle <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (active) begin
                        acc.wr    <= !wr_s;
                        acc.addr  <= addr;
                        acc.wdata <= data_in;
                        rd_cycle  <= wr_s;
                        if (ext_sel) begin
                            state <= ST_MEM;
                        end else begin
                            if (wr_s) rdata <= reg_rdata;
                            state <= ST_ACK;
                        end
                    end
                end
                ST_MEM: begin
                    if (mem_gnt) begin
                        if (!acc.wr) rdata <= mem_rdata;
                        state <= ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (!active) begin
                        rd_cycle <= 1'b0;
                        state    <= mode_intel ? ST_IDLE : ST_REL;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign reg_we    = (state == ST_IDLE) && active && !wr_s && !ext_sel;
    assign mem_req   = (state == ST_MEM);
    assign ack_phase = (state == ST_ACK);
    assign rel_phase = (state == ST_REL);
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
    import hostbus_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int NIRQ  = 4,
    localparam int IW   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_intel,
    input  logic              cs_n,
    input  logic              wr_rw,
    input  logic              rd_ds_n,
    input  logic [HB_AW-1:0]  addr,
    input  logic              ext_sel,
    input  logic [HB_DW-1:0]  data_in,
    output logic [HB_DW-1:0]  data_out,
    output logic              data_oe,
    output logic              hs_out,
    output logic              hs_oe,
    output logic              int_drive,
    input  logic [NIRQ-1:0]   irq_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic [HB_AW-1:0]  mem_addr,
    output logic [HB_DW-1:0]  mem_wdata,
    input  logic [HB_DW-1:0]  mem_rdata,
    input  logic              mem_gnt
);
    logic [2:0]       pins_s;
    logic             rf_we;
    logic [HB_DW-1:0] rf_rdata;
    hb_access_t       acc;
    logic             rd_cycle;
    logic             ack_phase;
    logic             rel_phase;

    hb_sync #(.W(3), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({cs_n, wr_rw, rd_ds_n}),
        .dout (pins_s)
    );

    hb_regfile #(.NREGS(NREGS), .DW(HB_DW)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .idx   (addr[IW-1:0]),
        .wdata (data_in),
        .rdata (rf_rdata)
    );

    hb_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mode_intel (mode_intel),
        .cs_s       (pins_s[2]),
        .wr_s       (pins_s[1]),
        .rd_s       (pins_s[0]),
        .ext_sel    (ext_sel),
        .addr       (addr),
        .data_in    (data_in),
        .reg_rdata  (rf_rdata),
        .mem_gnt    (mem_gnt),
        .mem_rdata  (mem_rdata),
        .reg_we     (rf_we),
        .acc        (acc),
        .mem_req    (mem_req),
        .rdata      (data_out),
        .rd_cycle   (rd_cycle),
        .ack_phase  (ack_phase),
        .rel_phase  (rel_phase)
    );

    assign mem_we    = acc.wr;
    assign mem_addr  = acc.addr;
    assign mem_wdata = acc.wdata;

    assign data_oe = rd_cycle && !cs_n && read_strobe(mode_intel, wr_rw, rd_ds_n);

    always_comb begin
        if (mode_intel) begin
            hs_oe  = !cs_n;
            hs_out = ack_phase;
        end else begin
            hs_oe  = ack_phase || rel_phase;
            hs_out = rel_phase;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) int_drive <= 1'b0;
        else     int_drive <= |irq_req;
    end
endmodule

// File: rtl/hb_checker.sv
module hb_checker #(
    parameter int NIRQ = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            mode_intel,
    input logic            cs_n,
    input logic            rd_ds_n,
    input logic            data_oe,
    input logic            hs_out,
    input logic            hs_oe,
    input logic            int_drive,
    input logic [NIRQ-1:0] irq_req,
    input logic            mem_req,
    input logic [14:0]     mem_addr,
    input logic [15:0]     mem_wdata,
    input logic            mem_gnt,
    input logic            rf_we
);
    logic acked;
    assign acked = mode_intel ? (hs_oe && hs_out) : (hs_oe && !hs_out);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req);
    assert_no_early_ack_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !acked);
    assert_mem_stable_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> $stable(mem_addr) && $stable(mem_wdata));
    assert_hiz_R5: assert property (@(posedge clk) disable iff (rst)
        mode_intel && cs_n |-> !hs_oe);
    assert_release_R6: assert property (@(posedge clk) disable iff (rst)
        !mode_intel && hs_oe && hs_out |=> !hs_oe);
    assert_oe_gate_R7: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> !cs_n && !rd_ds_n);
    assert_one_write_R8: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> !rf_we);
    assert_irq_follow_R10: assert property (@(posedge clk) disable iff (rst)
        (|irq_req) |=> int_drive);
endmodule

bind hostbus_slave hb_checker #(.NIRQ(NIRQ)) u_hb_checker (
    .clk        (clk),
    .rst        (rst),
    .mode_intel (mode_intel),
    .cs_n       (cs_n),
    .rd_ds_n    (rd_ds_n),
    .data_oe    (data_oe),
    .hs_out     (hs_out),
    .hs_oe      (hs_oe),
    .int_drive  (int_drive),
    .irq_req    (irq_req),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_gnt    (mem_gnt),
    .rf_we      (rf_we)
);

// File: tb/tb_hostbus_slave.sv
`timescale 1ns/1ps
module tb_hostbus_slave;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_intel = 1'b1;
    logic        cs_n = 1'b1;
    logic        wr_rw = 1'b1;
    logic        rd_ds_n = 1'b1;
    logic [14:0] addr = '0;
    logic        ext_sel = 1'b0;
    logic [15:0] data_in = '0;
    logic [15:0] data_out;
    logic        data_oe, hs_out, hs_oe, int_drive;
    logic [3:0]  irq_req = '0;
    logic        mem_req, mem_we;
    logic [14:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_gnt = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int lat = 1;
    int lat_cnt = 0;
    int wr_grants = 0;
    bit gnt_seen = 0;
    bit req_seen = 0;
    logic [14:0] last_addr;
    logic [15:0] last_wdata;
    logic [15:0] ref_regs [8];
    logic [15:0] ext_mem [int];
    logic [3:0]  irq_prev = '0;
    bit          rst_prev = 1;

    hostbus_slave dut (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ext_val(input logic [14:0] a);
        if (ext_mem.exists(int'(a))) return ext_mem[int'(a)];
        return {1'b0, a} ^ 16'h5A3C;
    endfunction

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            chk(0, "WDOG", "watchdog expired", cycles, 100000);
            summary();
        end
    end

    // memory responder (bench-side model of the memory)
    always @(negedge clk) begin
        if (mem_gnt) begin
            mem_gnt = 1'b0;
        end else if (mem_req) begin
            req_seen = 1;
            lat_cnt++;
            if (lat_cnt >= lat) begin
                lat_cnt = 0;
                gnt_seen = 1;
                last_addr = mem_addr;
                if (mem_we) begin
                    ext_mem[int'(mem_addr)] = mem_wdata;
                    last_wdata = mem_wdata;
                    wr_grants++;
                end else begin
                    mem_rdata = ext_val(mem_addr);
                end
                mem_gnt = 1'b1;
            end
        end else begin
            lat_cnt = 0;
        end
    end

    // per-clock reference comparisons
    always @(negedge clk) begin
        #1;
        chk(int_drive == (rst_prev ? 1'b0 : |irq_prev), "R10", "int_drive",
            int_drive, rst_prev ? 0 : |irq_prev);
        if (!rst) begin
            if (mode_intel)
                chk(hs_oe == !cs_n, "R5", "hs_oe vs cs_n", hs_oe, !cs_n);
            if (cs_n)
                chk(!data_oe, "R7", "data_oe with cs high", data_oe, 0);
        end
        irq_prev = irq_req;
        rst_prev = rst;
    end

    task automatic do_reset(input logic intel);
        @(negedge clk);
        mode_intel = intel;
        rst = 1'b1;
        cs_n = 1'b1; wr_rw = 1'b1; rd_ds_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) ref_regs[i] = '0;
        #1;
        chk(!data_oe && !mem_req && !int_drive, "R11", "reset outputs",
            {data_oe, mem_req, int_drive}, 0);
        if (!intel) chk(!hs_oe, "R11", "hs_oe idle after reset", hs_oe, 0);
    endtask

    task automatic access(input bit wr, input bit ext, input logic [14:0] a,
                          input logic [15:0] d, input int hold, input string req);
        logic [15:0] exp;
        bit got;
        int grants0;
        grants0 = wr_grants;
        gnt_seen = 0;
        exp = ext ? ext_val(a) : ref_regs[a[2:0]];
        @(negedge clk);
        addr = a; ext_sel = ext; data_in = d;
        wr_rw = mode_intel ? 1'b1 : !wr;
        rd_ds_n = 1'b1;
        cs_n = 1'b0;
        @(negedge clk);
        if (mode_intel && wr) wr_rw = 1'b0;
        else rd_ds_n = 1'b0;
        got = 0;
        for (int k = 0; k < 300 && !got; k++) begin
            @(negedge clk); #1;
            if (mode_intel ? (hs_oe && hs_out) : (hs_oe && !hs_out)) got = 1;
        end
        chk(got, req, "handshake completion", got, 1);
        if (ext) chk(gnt_seen, "R9", "completion after grant", gnt_seen, 1);
        if (!wr) begin
            chk(data_out == exp, req, "read data", data_out, exp);
            chk(data_oe, "R7", "data_oe during read", data_oe, 1);
        end else if (ext) begin
            chk(last_addr == a && last_wdata == d, "R4", "memory write addr/data",
                {last_addr, last_wdata}, {a, d});
        end else begin
            ref_regs[a[2:0]] = d;
        end
        if (ext && !wr) chk(last_addr == a, "R4", "memory read addr", last_addr, a);
        repeat (hold) @(negedge clk);
        @(negedge clk);
        wr_rw = mode_intel ? 1'b1 : wr_rw;
        rd_ds_n = 1'b1;
        #1;
        chk(!data_oe, "R7", "data_oe released with strobe", data_oe, 0);
        if (!mode_intel) begin
            got = 0;
            for (int k = 0; k < 10 && !got; k++) begin
                @(negedge clk); #1;
                if (hs_oe && hs_out) got = 1;
                else if (!hs_oe) k = 10;
            end
            chk(got, "R6", "one-clock high drive", got, 1);
            @(negedge clk); #1;
            chk(!hs_oe, "R6", "acknowledge released", hs_oe, 0);
        end
        @(negedge clk);
        cs_n = 1'b1;
        #1;
        if (mode_intel) chk(!hs_oe, "R5", "ready hi-Z after cs high", hs_oe, 0);
        if (wr && ext) chk(wr_grants - grants0 == 1, "R8", "writes per strobe",
                           wr_grants - grants0, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic ghost_strobes(input bit ext);
        req_seen = 0;
        @(negedge clk);
        addr = 15'h0002; ext_sel = ext; data_in = 16'hDEAD; cs_n = 1'b1;
        @(negedge clk); wr_rw = 1'b0;
        repeat (6) @(negedge clk);
        wr_rw = 1'b1; rd_ds_n = 1'b0;
        repeat (6) @(negedge clk);
        rd_ds_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!req_seen, "R3", "no memory request with cs high", req_seen, 0);
    endtask

    initial begin
        // ---- strap 1: separate strobes ----
        do_reset(1'b1);
        access(0, 0, 15'h0003, 16'h0, 0, "R11");          // register resets to 0
        access(1, 0, 15'h0003, 16'h1234, 0, "R1");
        access(0, 0, 15'h0003, 16'h0, 0, "R1");
        access(1, 0, 15'h000D, 16'hBEEF, 0, "R4");        // aliases to reg 5
        access(0, 0, 15'h0005, 16'h0, 0, "R4");
        lat = 1;
        access(0, 1, 15'h1234, 16'h0, 0, "R4");
        lat = 6;
        access(1, 1, 15'h7FFF, 16'hCAFE, 15, "R8");
        access(0, 1, 15'h7FFF, 16'h0, 3, "R9");
        ghost_strobes(0);
        ghost_strobes(1);
        access(0, 0, 15'h0002, 16'h0, 0, "R3");          // reg 2 untouched
        // both strobes low: write wins
        @(negedge clk);
        addr = 15'h0006; ext_sel = 0; data_in = 16'h00A5; cs_n = 0;
        @(negedge clk); wr_rw = 0; rd_ds_n = 0;
        repeat (8) @(negedge clk);
        wr_rw = 1; rd_ds_n = 1;
        repeat (6) @(negedge clk);
        cs_n = 1;
        ref_regs[6] = 16'h00A5;
        repeat (2) @(negedge clk);
        access(0, 0, 15'h0006, 16'h0, 0, "R1");
        // interrupts
        @(negedge clk); irq_req = 4'b0100;
        repeat (3) @(negedge clk); irq_req = 4'b0000;
        repeat (3) @(negedge clk); irq_req = 4'b1001;
        @(negedge clk); irq_req = 4'b0000;
        repeat (2) @(negedge clk);

        // ---- strap 0: level + data strobe ----
        do_reset(1'b0);
        access(1, 0, 15'h0001, 16'h5555, 0, "R2");
        access(0, 0, 15'h0001, 16'h0, 4, "R2");
        access(0, 0, 15'h0009, 16'h0, 0, "R4");           // alias of reg 1
        lat = 1;
        access(1, 1, 15'h0040, 16'h0F0F, 10, "R8");
        lat = 6;
        access(0, 1, 15'h0040, 16'h0, 0, "R9");
        access(0, 1, 15'h2222, 16'h0, 2, "R6");
        ghost_strobes(1);
        access(0, 0, 15'h0002, 16'h0, 0, "R3");
        @(negedge clk); irq_req = 4'b0010;
        repeat (2) @(negedge clk); irq_req = 4'b0000;
        repeat (3) @(negedge clk);
        summary();
    end
endmodule